// File: doc/BRIEF.md
# Power-On Reset and Output-Enable Sequencer

This block produces the internal reset of a video-decoder-style device and decides when its output drivers may leave high impedance. Four conditions put the device into reset: a bad digital supply, a bad analog supply, the chip-enable pin held low, and the line-locked clock being absent. The clock check runs on a free-running reference clock. A reset cause takes effect at once, without waiting for a clock edge. When the last cause goes away, the reset is released through a two-stage synchronizer on the line-locked clock.

After release, the block holds an active-low reset indicator low for a fixed number of line-locked clock cycles so that other circuits in the system can use it as their own reset. Output group A (clock, clock-reference, real-time control and status, general-purpose switch and serial-data drivers) is enabled as soon as the internal reset ends. Output group B (horizontal and vertical reference and sync drivers) stays in high impedance until software writes 1 to its enable bit. Every reset clears that bit. The sensing of supply voltages and the register bus are outside this block; they reach it as plain input signals. All pins are plain control pins with no handshake.

Top module: `por_oe_seq`

## Requirements
- R1: While `dig_pwr_ok` or `ana_pwr_ok` is 0, `core_rst_n` is 0 and both `grp_a_oe` and `grp_b_oe` are 0.
- R2: Any reset cause forces `grp_a_oe`, `grp_b_oe` and `core_rst_n` to 0 without waiting for a clock edge.
- R3: Driving `chip_en` to 0 forces a reset, even when the supplies are good and the clock is running.
- R4: After `core_rst_n` rises, `rst_ind_n` stays 0 for exactly PULSE_LEN (default 128) falling edges of `llc_clk` and then goes to 1.
- R5: `grp_a_oe` is 1 whenever `core_rst_n` is 1 and no reset cause is present.
- R6: `grp_b_oe` stays 0 after reset until `cfg_wr` is 1 with `cfg_wdata` set to 1 on a rising edge of `llc_clk`. It then becomes 1, and a later write with `cfg_wdata` set to 0 turns it off.
- R7: Every reset clears the group-B enable bit, so `grp_b_oe` is 0 after any reset until it is written again.
- R8: If `llc_clk` shows no edge for CLK_TIMEOUT (default 16) cycles of `ref_clk`, the block enters reset. It leaves reset again once the clock toggles.
- R9: If a reset cause returns while `rst_ind_n` is still low, the count starts again, and the next pulse lasts the full PULSE_LEN cycles.
- R10: A write to `cfg_wr` while `core_rst_n` is 0 has no effect on `grp_b_oe`.
- R11: After the last reset cause is removed, `core_rst_n` is still 0 after the first rising edge of `llc_clk` and is 1 after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock for the missing-clock detector |
| llc_clk | input | 1 | Line-locked clock; all sequencing runs on it |
| dig_pwr_ok | input | 1 | Digital supply above its threshold (asynchronous) |
| ana_pwr_ok | input | 1 | Analog supply above its threshold (asynchronous) |
| chip_en | input | 1 | Chip enable; 0 forces a reset (asynchronous) |
| cfg_wr | input | 1 | Write strobe for the group-B enable bit, synchronous to llc_clk |
| cfg_wdata | input | 1 | Value written to the group-B enable bit |
| core_rst_n | output | 1 | Internal reset, active low |
| rst_ind_n | output | 1 | Timed reset indicator for other system circuits, active low |
| grp_a_oe | output | 1 | Output enable for the automatically released group |
| grp_b_oe | output | 1 | Output enable for the register-released group |

## Verification
The assertions assume two things about the inputs. First, when `llc_clk` is running, it toggles well within CLK_TIMEOUT reference cycles. Second, `cfg_wr` and `cfg_wdata` change only away from the rising edge of `llc_clk`. The supply and chip-enable inputs may change at any time.

The stimulus meets these assumptions as follows. It runs `llc_clk` with a 20 ns period, so it toggles every 2.5 reference cycles of 4 ns. It drives `cfg_wr` and `cfg_wdata` just after a falling edge of `llc_clk`. When it needs a missing clock, it stops `llc_clk` completely rather than slowing it, so the missing-clock timeout is never approached only partly.

// File: rtl/por_pkg.sv
package por_pkg;
  localparam int unsigned DEF_PULSE_LEN   = 128;
  localparam int unsigned DEF_CLK_TIMEOUT = 16;
  localparam int unsigned SYNC_STAGES     = 2;
endpackage

// File: rtl/por_clk_monitor.sv
module por_clk_monitor #(
  parameter int unsigned TIMEOUT = por_pkg::DEF_CLK_TIMEOUT
) (
  input  logic ref_clk,
  input  logic arst_n,
  input  logic llc_clk,
  output logic missing
);
  localparam int unsigned CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

  logic [2:0]    lvl_q;
  logic [CW-1:0] idle_cnt;
  logic          edge_seen;

  assign edge_seen = lvl_q[2] ^ lvl_q[1];

  // sample the line-locked level; the third stage remembers the previous value
  always_ff @(posedge ref_clk or negedge arst_n) begin
    if (!arst_n) lvl_q <= '0;
    else         lvl_q <= {lvl_q[1:0], llc_clk};
  end

  always_ff @(posedge ref_clk or negedge arst_n) begin
    if (!arst_n) begin
      idle_cnt <= LIMIT;
      missing  <= 1'b1;
    end else begin
      if (edge_seen)              idle_cnt <= '0;
      else if (idle_cnt != LIMIT) idle_cnt <= idle_cnt + 1'b1;
      missing <= (idle_cnt == LIMIT);
    end
  end

  a_r8_timeout_flags: assert property (@(posedge ref_clk) disable iff (!arst_n)
    (idle_cnt == LIMIT) |=> missing);
  a_r8_edge_clears: assert property (@(posedge ref_clk) disable iff (!arst_n)
    edge_seen |=> (idle_cnt == '0));
endmodule

// File: rtl/por_rst_sync.sv
module por_rst_sync #(
  parameter int unsigned STAGES = por_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain[STAGES-1];

  a_r11_release_via_chain: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(chain[STAGES-1]) |-> $past(chain[0]));
endmodule

// File: rtl/por_ind_pulse.sv
module por_ind_pulse #(
  parameter int unsigned PULSE_LEN = por_pkg::DEF_PULSE_LEN
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int unsigned CW = $clog2(PULSE_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(PULSE_LEN - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      cnt  <= cnt + 1'b1;
      done <= (cnt == LAST);
    end
  end

  a_r4_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  a_r9_fresh_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(cnt) == LAST));
endmodule

// File: rtl/por_oe_seq.sv
module por_oe_seq #(
  parameter int unsigned PULSE_LEN   = por_pkg::DEF_PULSE_LEN,
  parameter int unsigned CLK_TIMEOUT = por_pkg::DEF_CLK_TIMEOUT
) (
  input  logic ref_clk,
  input  logic llc_clk,
  input  logic dig_pwr_ok,
  input  logic ana_pwr_ok,
  input  logic chip_en,
  input  logic cfg_wr,
  input  logic cfg_wdata,
  output logic core_rst_n,
  output logic rst_ind_n,
  output logic grp_a_oe,
  output logic grp_b_oe
);
  logic pwr_good;
  logic clk_missing;
  logic no_cause;
  logic ind_done;
  logic grp_b_en;

  assign pwr_good = dig_pwr_ok & ana_pwr_ok;

  por_clk_monitor #(.TIMEOUT(CLK_TIMEOUT)) u_mon (
    .ref_clk (ref_clk),
    .arst_n  (pwr_good),
    .llc_clk (llc_clk),
    .missing (clk_missing)
  );

  assign no_cause = pwr_good & chip_en & ~clk_missing;

  por_rst_sync #(.STAGES(por_pkg::SYNC_STAGES)) u_sync (
    .clk    (llc_clk),
    .arst_n (no_cause),
    .rst_n  (core_rst_n)
  );

  por_ind_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk   (llc_clk),
    .rst_n (core_rst_n),
    .done  (ind_done)
  );

  always_ff @(posedge llc_clk or negedge core_rst_n) begin
    if (!core_rst_n)  grp_b_en <= 1'b0;
    else if (cfg_wr)  grp_b_en <= cfg_wdata;
  end

  assign rst_ind_n = ind_done;
  assign grp_a_oe  = core_rst_n & no_cause;
  assign grp_b_oe  = grp_b_en & no_cause;

  a_r5_grp_a_needs_release: assert property (@(posedge llc_clk) disable iff (!no_cause)
    grp_a_oe |-> core_rst_n);
  a_r7_b_off_at_release: assert property (@(posedge llc_clk) disable iff (!no_cause)
    $rose(core_rst_n) |-> !grp_b_en);
  a_r6_b_only_by_write: assert property (@(posedge llc_clk) disable iff (!core_rst_n)
    !$stable(grp_b_en) |-> $past(cfg_wr));
  a_r4_ind_low_before_pulse: assert property (@(posedge llc_clk) disable iff (!no_cause)
    !core_rst_n |-> !rst_ind_n);
endmodule

// File: tb/por_oe_seq_tb.sv
module por_oe_seq_tb;
  localparam int LEN = 128;

  logic ref_clk = 0, llc_clk = 0, llc_run = 1;
  logic dig_ok = 0, ana_ok = 0, ce = 0, wr = 0, wd = 0;
  logic core_rst_n, rst_ind_n, grp_a_oe, grp_b_oe;
  int checks = 0, fails = 0;
  int exp_q[$];
  bit finished = 0;

  always #2 ref_clk = ~ref_clk;
  initial forever begin #10; if (llc_run) llc_clk = ~llc_clk; end

  por_oe_seq u_dut (
    .ref_clk(ref_clk), .llc_clk(llc_clk), .dig_pwr_ok(dig_ok), .ana_pwr_ok(ana_ok),
    .chip_en(ce), .cfg_wr(wr), .cfg_wdata(wd), .core_rst_n(core_rst_n),
    .rst_ind_n(rst_ind_n), .grp_a_oe(grp_a_oe), .grp_b_oe(grp_b_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_all_off(input string req);
    check(grp_a_oe == 0 && grp_b_oe == 0 && core_rst_n == 0, req,
          {grp_a_oe, grp_b_oe, core_rst_n}, 0);
  endtask

  task automatic wait_pulse_end();
    while (!rst_ind_n) @(negedge llc_clk);
    @(negedge llc_clk);
  endtask

  task automatic write_b(input logic v);
    @(negedge llc_clk); wr = 1; wd = v;
    @(negedge llc_clk); wr = 0; wd = 0;
  endtask

  // monitor: measures each indicator pulse, compares against the scoreboard
  initial forever begin
    int n;
    bit aborted;
    @(posedge core_rst_n);
    n = 0; aborted = 0;
    forever begin
      @(negedge llc_clk);
      if (!core_rst_n) begin aborted = 1; break; end
      if (rst_ind_n) break;
      n++;
    end
    if (!aborted) begin
      if (exp_q.size() == 0) check(0, "R4 unexpected pulse", n, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(n == e, "R4/R9 pulse length", n, e);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #50;
    chk_all_off("R1 power-up");
    check(rst_ind_n == 0, "R1 indicator", rst_ind_n, 0);
    // supplies good but chip_en low: still reset (R3)
    dig_ok = 1; ana_ok = 1;
    #200;
    chk_all_off("R3 chip_en low");
    // release, measure synchronizer latency (R11)
    exp_q.push_back(LEN);
    @(negedge llc_clk); ce = 1;
    @(posedge llc_clk); #1;
    check(core_rst_n == 0, "R11 after first edge", core_rst_n, 0);
    @(posedge llc_clk); #1;
    check(core_rst_n == 1, "R11 after second edge", core_rst_n, 1);
    check(grp_a_oe == 1, "R5 group A on", grp_a_oe, 1);
    check(grp_b_oe == 0, "R6 group B off", grp_b_oe, 0);
    wait_pulse_end();
    check(rst_ind_n == 1, "R4 indicator high", rst_ind_n, 1);
    // enable group B by write
    write_b(1); #1;
    check(grp_b_oe == 1, "R6 write enables B", grp_b_oe, 1);
    write_b(0); #1;
    check(grp_b_oe == 0, "R6 write disables B", grp_b_oe, 0);
    write_b(1);
    // analog supply drop: immediate off (R1, R2)
    #3; ana_ok = 0; #1;
    chk_all_off("R2 analog drop immediate");
    check(rst_ind_n == 0, "R2 indicator", rst_ind_n, 0);
    #100;
    exp_q.push_back(LEN);
    ana_ok = 1;
    repeat (4) @(negedge llc_clk);
    check(grp_b_oe == 0, "R7 B cleared by reset", grp_b_oe, 0);
    wait_pulse_end();
    // digital supply drop
    write_b(1);
    #3; dig_ok = 0; #1;
    chk_all_off("R1 digital drop");
    #100;
    // write during reset ignored (R10)
    @(negedge llc_clk); wr = 1; wd = 1;
    @(negedge llc_clk); wr = 0; wd = 0;
    exp_q.push_back(LEN);
    dig_ok = 1;
    repeat (4) @(negedge llc_clk); #1;
    check(grp_b_oe == 0, "R10 write in reset ignored", grp_b_oe, 0);
    wait_pulse_end();
    // missing clock (R8)
    write_b(1);
    @(posedge llc_clk); llc_run = 0;
    #40;
    check(core_rst_n == 1, "R8 short gap tolerated", core_rst_n, 1);
    #100;
    chk_all_off("R8 missing clock");
    exp_q.push_back(LEN);
    llc_run = 1;
    repeat (6) @(negedge llc_clk);
    check(core_rst_n == 1 && grp_a_oe == 1, "R8 recovery", core_rst_n, 1);
    check(grp_b_oe == 0, "R7 B cleared after clock loss", grp_b_oe, 0);
    wait_pulse_end();
    // reassert mid-pulse (R9)
    @(negedge llc_clk); ce = 0;
    #60;
    @(negedge llc_clk); ce = 1;
    repeat (50) @(negedge llc_clk);
    check(rst_ind_n == 0, "R9 mid pulse low", rst_ind_n, 0);
    ce = 0; #1;
    chk_all_off("R3 chip_en mid pulse");
    #100;
    exp_q.push_back(LEN);
    ce = 1;
    repeat (3) @(negedge llc_clk);
    wait_pulse_end();
    repeat (5) @(negedge llc_clk);
    check(exp_q.size() == 0, "R9 all pulses seen", exp_q.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule